// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a total element count that may be larger than the maximum vector length into a series of vector-length settings. Each setting is no longer than the maximum vector length. A start pulse captures the count. The block then presents one chunk at a time on a ready/valid port. Each chunk carries a length, which is the value to load into the vector length register, and the element offset where that chunk begins.

The odd-sized remainder (count mod maximum length) comes first. Every chunk after it is full length. When the count divides evenly, no empty chunk is issued and the sequence opens with a full chunk. The final chunk is flagged. A one-cycle done pulse follows its acceptance. The block does not execute the chunks and does not generate addresses for them.

Top module: `strip_seq`

## Requirements
- R1: With no sequence in progress, a start pulse with a nonzero count captures the count, and the first chunk is valid in the cycle after the start.
- R2: Every presented chunk length lies between 1 and MAX_VL inclusive, so the vector length register is never loaded with more than MAX_VL.
- R3: The first chunk length is count mod MAX_VL. When that value is zero, the first chunk has length MAX_VL.
- R4: Every chunk after the first has length MAX_VL.
- R5: The first chunk offset is 0. Each later offset equals the previous offset plus the previous length.
- R6: While a chunk is valid and not accepted (ready low), its length, offset and last flag stay unchanged and valid stays high.
- R7: Exactly ceil(count / MAX_VL) chunks are presented. The last flag is high on the final chunk only. done_o is high for exactly one cycle, the cycle after the final chunk is accepted, and valid is low in that cycle.
- R8: A start with count 0 presents no chunk. done_o pulses in the cycle after the start.
- R9: A start pulse while a chunk is valid is ignored. The running sequence continues with unchanged values.
- R10: After reset, chunk_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures count_i when idle |
| count_i | input | CNT_W (32) | Total element count, unsigned |
| chunk_valid_o | output | 1 | A chunk is presented |
| chunk_ready_i | input | 1 | Consumer accepts the presented chunk |
| chunk_len_o | output | LEN_W (7) | Chunk length for the vector length register |
| chunk_off_o | output | CNT_W (32) | Element offset of the chunk |
| chunk_last_o | output | 1 | Presented chunk is the final one |
| done_o | output | 1 | One-cycle pulse after the final chunk is accepted |

## Verification
The bench builds the block with the default MAX_VL of 64 and a 32-bit count, which selects the shift-and-mask split. Counts of 0, 1, 63, 64, 65, exact multiples, and 192017 (3001 chunks) cover the skipped empty remainder, the single-chunk case and long offset accumulation. Stalled handshakes, start pulses injected during a stall, and a reset in mid-sequence exercise the hold and ignore rules.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} strip_state_e;
endpackage

// File: rtl/strip_split.sv
module strip_split #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [LEN_W-1:0] head_len_o,
  output logic [CNT_W-1:0] n_chunks_o,
  output logic             empty_o
);
  localparam int unsigned SH      = $clog2(MAX_VL);
  localparam bit          IS_POW2 = ((1 << SH) == MAX_VL);

  logic [LEN_W-1:0] rem;
  logic [CNT_W-1:0] quo;

  generate
    if (IS_POW2) begin : g_shift
      assign rem = LEN_W'(count_i[SH-1:0]);
      assign quo = count_i >> SH;
    end else begin : g_div
      assign rem = LEN_W'(count_i % CNT_W'(MAX_VL));
      assign quo = count_i / CNT_W'(MAX_VL);
    end
  endgenerate

  // zero remainder: skip the empty head, open with a full chunk
  assign head_len_o = (rem == '0) ? LEN_W'(MAX_VL) : rem;
  assign n_chunks_o = quo + CNT_W'(rem != '0);
  assign empty_o    = (count_i == '0);

  always_comb begin
    AST_HEAD_IN_RANGE: assert (head_len_o != '0 && head_len_o <= LEN_W'(MAX_VL)); // R2
  end
endmodule

// File: rtl/strip_ctrl.sv
module strip_ctrl
  import strip_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] head_len_i,
  input  logic [CNT_W-1:0] n_chunks_i,
  input  logic             empty_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o,
  output logic             done_o,
  output logic             load_o,
  output logic             step_o
);
  strip_state_e     state_q;
  logic [CNT_W-1:0] left_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;

  assign valid_o = (state_q == ST_RUN);
  assign last_o  = valid_o && (left_q == CNT_W'(1));
  assign len_o   = len_q;
  assign done_o  = done_q;
  assign load_o  = (state_q == ST_IDLE) && start_i && !empty_i;
  assign step_o  = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (empty_i) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              left_q  <= n_chunks_i;
              len_q   <= head_len_i;
            end
          end
        end
        ST_RUN: begin
          if (ready_i) begin
            if (left_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              left_q <= left_q - CNT_W'(1);
              len_q  <= LEN_W'(MAX_VL);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o != '0 && len_o <= LEN_W'(MAX_VL))); // R2
  AST_TAIL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o) |=> (valid_o && len_o == LEN_W'(MAX_VL))); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> (done_o && !valid_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_LEFT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (left_q != '0)); // R7
endmodule

// File: rtl/strip_acc.sv
module strip_acc #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] off_o
);
  logic [CNT_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (load_i) off_q <= '0;
    else if (step_i) off_q <= off_q + CNT_W'(len_i);
  end

  assign off_o = off_q;

  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (off_o == $past(off_o) + CNT_W'($past(len_i)))); // R5
  AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (off_o == '0)); // R5
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             chunk_valid_o,
  input  logic             chunk_ready_i,
  output logic [LEN_W-1:0] chunk_len_o,
  output logic [CNT_W-1:0] chunk_off_o,
  output logic             chunk_last_o,
  output logic             done_o
);
  logic [LEN_W-1:0] head_len;
  logic [CNT_W-1:0] n_chunks;
  logic             empty;
  logic             load;
  logic             step;

  strip_split #(.CNT_W(CNT_W), .MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_split (
    .count_i   (count_i),
    .head_len_o(head_len),
    .n_chunks_o(n_chunks),
    .empty_o   (empty)
  );

  strip_ctrl #(.CNT_W(CNT_W), .MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .head_len_i(head_len),
    .n_chunks_i(n_chunks),
    .empty_i   (empty),
    .ready_i   (chunk_ready_i),
    .valid_o   (chunk_valid_o),
    .len_o     (chunk_len_o),
    .last_o    (chunk_last_o),
    .done_o    (done_o),
    .load_o    (load),
    .step_o    (step)
  );

  strip_acc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .len_i (chunk_len_o),
    .off_o (chunk_off_o)
  );

  AST_START_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chunk_valid_o && start_i && count_i != '0) |=> (chunk_valid_o && chunk_off_o == '0)); // R1
  AST_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chunk_valid_o && start_i && count_i == '0) |=> (done_o && !chunk_valid_o)); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_valid_o && !chunk_ready_i) |=> (chunk_valid_o && $stable(chunk_len_o)
      && $stable(chunk_off_o) && $stable(chunk_last_o))); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_valid_o && start_i && !(chunk_ready_i && chunk_last_o)) |=> chunk_valid_o); // R9
endmodule

// File: tb/strip_seq_bench.sv
module strip_seq_bench;
  localparam int unsigned CLK_P  = 10;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned MAX_VL = 64;
  localparam int unsigned LEN_W  = $clog2(MAX_VL + 1);
  localparam int unsigned N_VEC  = 10;
  // count, stall pattern enable, inject start during stall
  localparam int unsigned VEC_N[N_VEC]    = '{1, 63, 64, 65, 128, 130, 200, 1000, 640, 192017};
  localparam bit          VEC_STALL[N_VEC] = '{0, 1, 0, 1, 1, 0, 1, 1, 0, 0};
  localparam bit          VEC_POKE[N_VEC]  = '{0, 0, 0, 1, 0, 0, 1, 1, 0, 0};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic             ready = 1'b0;
  logic             valid;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] off;
  logic             last;
  logic             done;

  int unsigned checks = 0;
  int unsigned failures = 0;

  always #(CLK_P / 2) clk = ~clk;

  strip_seq #(.CNT_W(CNT_W), .MAX_VL(MAX_VL)) u_strip_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .count_i      (count),
    .chunk_valid_o(valid),
    .chunk_ready_i(ready),
    .chunk_len_o  (len),
    .chunk_off_o  (off),
    .chunk_last_o (last),
    .done_o       (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_chunk(input string req, input int unsigned el,
                           input int unsigned eo, input bit el_last);
    chk(valid == 1'b1, req, "valid", valid, 1);
    chk(len == LEN_W'(el), req, "len", len, el);
    chk(off == CNT_W'(eo), req, "off", off, eo);
    chk(last == el_last, req, "last", last, el_last);
    chk(done == 1'b0, req, "done during chunk", done, 0);
  endtask

  task automatic run_seq(input int unsigned n, input bit stall, input bit poke);
    int unsigned rem = n % MAX_VL;
    int unsigned nch = n / MAX_VL + ((rem != 0) ? 1 : 0);
    int unsigned eo = 0;
    @(negedge clk);
    start = 1'b1;
    count = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    for (int unsigned i = 0; i < nch; i++) begin
      int unsigned el = (i == 0 && rem != 0) ? rem : MAX_VL;
      bit el_last = (i == nch - 1);
      // R1 R3 R4 R5 R7: chunk contents
      chk_chunk((i == 0) ? "R3" : "R4", el, eo, el_last);
      if (stall && (i % 3 == 1 || el_last)) begin
        ready = 1'b0;
        if (poke) begin
          start = 1'b1;
          count = CNT_W'(7);
        end
        @(negedge clk);
        start = 1'b0;
        chk_chunk("R6", el, eo, el_last);
        if (poke) chk_chunk("R9", el, eo, el_last);
      end
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      eo += el;
    end
    chk(done == 1'b1, "R7", "done after last", done, 1);
    chk(valid == 1'b0, "R7", "valid with done", valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done single cycle", done, 0);
    chk(valid == 1'b0, "R7", "no extra chunk", valid, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    @(negedge clk);
    // R10: reset state
    chk(valid == 1'b0, "R10", "valid in reset", valid, 0);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R10", "valid after reset", valid, 0);
    chk(done == 1'b0, "R10", "done after reset", done, 0);

    for (int v = 0; v < N_VEC; v++) begin
      run_seq(VEC_N[v], VEC_STALL[v], VEC_POKE[v]);
    end

    // R8: zero count
    @(negedge clk);
    start = 1'b1;
    count = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R8", "done on zero count", done, 1);
    chk(valid == 1'b0, "R8", "no chunk on zero count", valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
    chk(valid == 1'b0, "R8", "still no chunk", valid, 0);

    // R10: reset mid-sequence, then a fresh sequence
    @(negedge clk);
    start = 1'b1;
    count = CNT_W'(300);
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b1, "R1", "valid after start", valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0, "R10", "valid after mid reset", valid, 0);
    chk(done == 1'b0, "R10", "done after mid reset", done, 0);
    rst_n = 1'b1;
    run_seq(130, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule